// File: doc/BRIEF.md
# I2C Master Bit Engine with Address Collision Recovery

This block is the bit-level half of an I2C master. It drives the two open-drain bus lines only through output enables: an enable of 1 pulls the line low, 0 releases it to the pull-up. It also reads both lines back through a small synchronizer. On one command it produces a START (or repeated START) followed by the slave address byte, a single data byte written or read, or a STOP. Sequencing several bytes into a transaction is left to the caller. After every byte it keeps SCL low, so the caller has the bus until it issues the next command.

The engine honours clock stretching. Every high half-period is timed only from the moment SCL is actually seen high, so a slave that holds SCL low simply lengthens that bit. While the address byte goes out, the engine checks each bit it sends as a 1. If the bus reads low there, another master has won. The engine then flags the collision for one cycle and lets go of both lines. It waits for SDA to return high, then waits until neither line has moved for a fixed idle window. It then finishes the command with a restart request in place of an acknowledge result.

Timing comes from parameters: `HALF_CYC` is the number of system clocks in each SCL half-period. The idle window is `IDLE_US` microseconds derived from `CLK_HZ`.

Top module: `i2c_bitmaster`

## Requirements
- R1: After reset, both output enables are 0 (bus released), and busy and done are 0.
- R2: A start command puts a START on the bus: SDA falls while SCL is high, then SCL falls. The address byte follows, MSB first. It is formed as `{cmd_data[6:0], rw}`, where rw is 1 for start-read (code 2) and 0 for start-write (code 1).
- R3: After the eighth bit of any byte, the engine releases SDA and clocks a ninth bit. A low SDA there gives ack_ok=1 and a high SDA gives ack_ok=0. SCL is then held low (scl_oe=1) until the next command.
- R4: A write command (code 3) sends cmd_data MSB first. A 1 bit is a released SDA and a 0 bit is a driven-low SDA. The slave's acknowledge is reported as in R3.
- R5: A read command (code 4) releases SDA and clocks in eight bits MSB first, which appear on rx_data at done. In the ninth clock it drives SDA low when cmd_nack=0 and releases it when cmd_nack=1.
- R6: A stop command (code 5) pulls SCL low, then SDA low, then releases SCL, then releases SDA while SCL is high. Afterwards both enables are 0.
- R7: Each SCL high phase lasts at least HALF_CYC clocks, counted only after SCL reads high. A slave holding SCL low therefore delays sampling and completion without corrupting data.
- R8: During the address byte, a bit sent as 1 that samples low raises collision for exactly one cycle. In that same cycle both enables are 0. Data bytes never raise collision.
- R9: After a collision the command ends only after SDA reads high and then neither line has changed for IDLE_US microseconds. It ends with done=1 and restart_req=1. A following start succeeds normally.
- R10: busy rises the cycle after a command is accepted and falls in the cycle where done pulses for one clock. Commands presented while busy are ignored.
- R11: A start command issued while the engine holds SCL low after a byte produces a valid repeated START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken only when busy is 0 |
| cmd_code | input | 3 | 1 start-write, 2 start-read, 3 write, 4 read, 5 stop; others ignored |
| cmd_data | input | 8 | Address in [6:0] for starts, byte for writes |
| cmd_nack | input | 1 | For reads: 1 releases SDA in the ninth clock |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion strobe |
| ack_ok | output | 1 | Ninth-bit SDA was low, valid with done |
| rx_data | output | 8 | Received byte, valid with done |
| restart_req | output | 1 | With done: the command was abandoned after a collision |
| collision | output | 1 | One-cycle lost-arbitration event |
| sda_in | input | 1 | SDA line level |
| scl_in | input | 1 | SCL line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| scl_oe | output | 1 | 1 pulls SCL low |

## Verification
The hardest state to reach from the ports is the collision path. It needs a second driver that wins an address bit and then keeps SDA low for a while, so that both the wait-for-high and the idle window are exercised. The bench adds its own open-drain rival to the wired-AND bus. The rival grabs SDA on the START edge, is released a fixed time after the collision pulse, and the bench measures the quiet time between the last line edge and done. A slave model with a programmable stretch length, combined with random addresses, data, directions and stretch values, covers stretching at data and acknowledge bits.

// File: rtl/i2cm_pkg.sv
// Package: command codes and controller states shared by the I2C bit engine.
// Assumes: command codes are stable encodings seen by the caller.
package i2cm_pkg;

    typedef enum logic [2:0] {
        CMD_NONE     = 3'd0,
        CMD_START_WR = 3'd1,
        CMD_START_RD = 3'd2,
        CMD_WRITE    = 3'd3,
        CMD_READ     = 3'd4,
        CMD_STOP     = 3'd5
    } cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S0,
        ST_S1,
        ST_S2,
        ST_BSET,
        ST_BLO,
        ST_BHI,
        ST_P0,
        ST_P1,
        ST_P2,
        ST_P3,
        ST_CWAIT,
        ST_CIDLE
    } state_e;

    localparam int FRAME_BITS = 9;

endpackage

// File: rtl/i2cm_sync.sv
// Module: input synchronizer for one bus line.
// Assumes: the line idles high, so the chain resets to 1; STAGES >= 1.
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    generate
        if (STAGES <= 1) begin : g_one
            logic r;
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= 1'b1;
                else        r <= d;
            end
            assign q = r;
        end else begin : g_many
            logic [STAGES-1:0] r;
            // Shift chain of STAGES registers.
            always_ff @(posedge clk) begin
                if (!rst_n) r <= '1;
                else        r <= {r[STAGES-2:0], d};
            end
            assign q = r[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/i2cm_half_timer.sv
// Module: half-period timer. Counts while run is high and pulses tick
// on the HALF_CYC-th counted clock; clears whenever run drops.
// Assumes: HALF_CYC >= 2.
module i2cm_half_timer #(
    parameter int HALF_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = $clog2(HALF_CYC + 1);

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    // Count enabled clocks, restart on tick or when paused.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(HALF_CYC));

endmodule

// File: rtl/i2cm_idle_watch.sv
// Module: bus-quiet detector. While enabled, counts clocks with no edge on
// either synchronized line; quiet rises once IDLE_CYC such clocks have passed.
// Assumes: inputs are already synchronized.
module i2cm_idle_watch #(
    parameter int IDLE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic sda_s,
    input  logic scl_s,
    output logic quiet
);
    localparam int CW = $clog2(IDLE_CYC + 1);

    logic [CW-1:0] cnt;
    logic          sda_d, scl_d;
    logic          edge_seen;

    assign edge_seen = (sda_d != sda_s) || (scl_d != scl_s);
    assign quiet     = en && (cnt == CW'(IDLE_CYC));

    // Remember last line levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sda_d <= 1'b1;
            scl_d <= 1'b1;
        end else begin
            sda_d <= sda_s;
            scl_d <= scl_s;
        end
    end

    // Quiet-time counter, cleared by any edge or when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cnt <= '0;
        else if (!en || edge_seen)   cnt <= '0;
        else if (cnt != CW'(IDLE_CYC)) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/i2c_bitmaster.sv
// Module: I2C master bit engine. Executes one command at a time (start with
// address, write byte, read byte, stop) on open-drain lines driven through
// output enables, honours clock stretching and recovers from address-phase
// collisions by backing off until the bus is quiet.
// Assumes: external pull-ups; caller sequences bytes and issues STOP.
module i2c_bitmaster #(
    parameter int HALF_CYC    = 5,
    parameter int CLK_HZ      = 100_000_000,
    parameter int IDLE_US     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic [7:0] cmd_data,
    input  logic       cmd_nack,
    output logic       busy,
    output logic       done,
    output logic       ack_ok,
    output logic [7:0] rx_data,
    output logic       restart_req,
    output logic       collision,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       sda_oe,
    output logic       scl_oe
);
    import i2cm_pkg::*;

    localparam int IDLE_CYC = (CLK_HZ / 1_000_000) * IDLE_US;
    localparam logic [3:0] LAST_IDX = 4'(FRAME_BITS - 1);

    state_e     state;
    logic [8:0] frame;
    logic [7:0] rxsh;
    logic [3:0] bit_idx;
    logic       addr_ph;
    logic       sda_oe_q, scl_oe_q;
    logic [1:0] line_raw, line_s;
    logic       sda_s, scl_s;
    logic       run, tick, quiet;
    logic       cmd_ok, last_bit;
    cmd_e       code;

    assign code   = cmd_e'(cmd_code);
    assign cmd_ok = (code == CMD_START_WR) || (code == CMD_START_RD) ||
                    (code == CMD_WRITE) || (code == CMD_READ) || (code == CMD_STOP);

    assign line_raw = {scl_in, sda_in};

    // One synchronizer per bus line.
    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_sync
            i2cm_sync #(.STAGES(SYNC_STAGES)) i_sync (
                .clk  (clk),
                .rst_n(rst_n),
                .d    (line_raw[g]),
                .q    (line_s[g])
            );
        end
    endgenerate

    assign sda_s = line_s[0];
    assign scl_s = line_s[1];

    // Timer runs in timed states; high phases count only once SCL reads high.
    always_comb begin
        case (state)
            ST_S0, ST_S2, ST_BLO, ST_P0, ST_P1, ST_P3: run = 1'b1;
            ST_S1, ST_BHI, ST_P2:                      run = scl_s;
            default:                                   run = 1'b0;
        endcase
    end

    i2cm_half_timer #(.HALF_CYC(HALF_CYC)) i_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    i2cm_idle_watch #(.IDLE_CYC(IDLE_CYC)) i_idle (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (state == ST_CIDLE),
        .sda_s(sda_s),
        .scl_s(scl_s),
        .quiet(quiet)
    );

    assign last_bit = (bit_idx == LAST_IDX);

    // Command sequencer: start, bit framing, stop and collision recovery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            frame       <= '1;
            rxsh        <= '0;
            bit_idx     <= '0;
            addr_ph     <= 1'b0;
            sda_oe_q    <= 1'b0;
            scl_oe_q    <= 1'b0;
            busy        <= 1'b0;
            done        <= 1'b0;
            ack_ok      <= 1'b0;
            rx_data     <= '0;
            restart_req <= 1'b0;
            collision   <= 1'b0;
        end else begin
            done        <= 1'b0;
            restart_req <= 1'b0;
            collision   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid && cmd_ok) begin
                        busy    <= 1'b1;
                        bit_idx <= '0;
                        addr_ph <= (code == CMD_START_WR) || (code == CMD_START_RD);
                        case (code)
                            CMD_START_WR, CMD_START_RD: begin
                                frame    <= {cmd_data[6:0], code == CMD_START_RD, 1'b1};
                                sda_oe_q <= 1'b0;
                                state    <= ST_S0;
                            end
                            CMD_WRITE: begin
                                frame <= {cmd_data, 1'b1};
                                state <= ST_BSET;
                            end
                            CMD_READ: begin
                                frame <= {8'hFF, cmd_nack};
                                state <= ST_BSET;
                            end
                            default: begin
                                scl_oe_q <= 1'b1;
                                state    <= ST_P0;
                            end
                        endcase
                    end
                end
                ST_S0: if (tick) begin
                    scl_oe_q <= 1'b0;
                    state    <= ST_S1;
                end
                ST_S1: if (tick) begin
                    sda_oe_q <= 1'b1;
                    state    <= ST_S2;
                end
                ST_S2: if (tick) begin
                    scl_oe_q <= 1'b1;
                    state    <= ST_BSET;
                end
                ST_BSET: begin
                    sda_oe_q <= ~frame[8];
                    state    <= ST_BLO;
                end
                ST_BLO: if (tick) begin
                    scl_oe_q <= 1'b0;
                    state    <= ST_BHI;
                end
                ST_BHI: if (tick) begin
                    rxsh <= {rxsh[6:0], sda_s};
                    if (addr_ph && !last_bit && frame[8] && !sda_s) begin
                        sda_oe_q  <= 1'b0;
                        scl_oe_q  <= 1'b0;
                        collision <= 1'b1;
                        state     <= ST_CWAIT;
                    end else begin
                        scl_oe_q <= 1'b1;
                        if (last_bit) begin
                            done    <= 1'b1;
                            busy    <= 1'b0;
                            ack_ok  <= ~sda_s;
                            rx_data <= rxsh;
                            state   <= ST_IDLE;
                        end else begin
                            frame   <= {frame[7:0], 1'b0};
                            bit_idx <= bit_idx + 4'd1;
                            state   <= ST_BSET;
                        end
                    end
                end
                ST_CWAIT: if (sda_s) state <= ST_CIDLE;
                ST_CIDLE: if (quiet) begin
                    done        <= 1'b1;
                    restart_req <= 1'b1;
                    ack_ok      <= 1'b0;
                    busy        <= 1'b0;
                    state       <= ST_IDLE;
                end
                ST_P0: if (tick) begin
                    sda_oe_q <= 1'b1;
                    state    <= ST_P1;
                end
                ST_P1: if (tick) begin
                    scl_oe_q <= 1'b0;
                    state    <= ST_P2;
                end
                ST_P2: if (tick) begin
                    sda_oe_q <= 1'b0;
                    state    <= ST_P3;
                end
                ST_P3: if (tick) begin
                    done  <= 1'b1;
                    busy  <= 1'b0;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign sda_oe = sda_oe_q;
    assign scl_oe = scl_oe_q;

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r10_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && cmd_valid && cmd_ok) |=> busy);

    a_r7_hold_while_stretched: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BHI && !scl_s) |=> (state == ST_BHI));

    a_r8_release_on_collision: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> (!sda_oe && !scl_oe));

    a_r8_address_only: assert property (@(posedge clk) disable iff (!rst_n)
        collision |-> addr_ph);

    a_r9_restart_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |-> done);

endmodule

// File: tb/test_i2c_bitmaster.sv
module test_i2c_bitmaster;
    localparam int HALF   = 5;
    localparam int CLKHZ  = 10_000_000;
    localparam int TB_IDLE = (CLKHZ / 1_000_000) * 20;
    localparam logic [6:0] SLV = 7'h3A;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic [7:0] cmd_data = 8'd0;
    logic cmd_nack = 1'b0;
    logic busy, done, ack_ok, restart_req, collision, sda_oe, scl_oe;
    logic [7:0] rx_data;

    logic s_sda_low = 1'b0, s_scl_low = 1'b0, rival_low = 1'b0;
    logic sda_w, scl_w;
    assign sda_w = !(sda_oe || s_sda_low || rival_low);
    assign scl_w = !(scl_oe || s_scl_low);

    i2c_bitmaster #(.HALF_CYC(HALF), .CLK_HZ(CLKHZ), .IDLE_US(20), .SYNC_STAGES(2)) i_i2c_bitmaster (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_data(cmd_data), .cmd_nack(cmd_nack), .busy(busy), .done(done),
        .ack_ok(ack_ok), .rx_data(rx_data), .restart_req(restart_req),
        .collision(collision), .sda_in(sda_w), .scl_in(scl_w),
        .sda_oe(sda_oe), .scl_oe(scl_oe));

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int cyc = 0, last_edge = 0, hi_run = 0, min_hi = 1000000;
    logic sda_d = 1'b1, scl_d = 1'b1;
    int col_cnt = 0, col_bad = 0;

    // Bus monitors: edge time, SCL high width, collision strobe.
    always @(posedge clk) begin
        cyc++;
        if (sda_w !== sda_d || scl_w !== scl_d) last_edge = cyc;
        if (scl_w) hi_run++;
        else if (hi_run > 0) begin
            if (hi_run < min_hi) min_hi = hi_run;
            hi_run = 0;
        end
        sda_d = sda_w;
        scl_d = scl_w;
    end
    always @(negedge clk) if (rst_n && collision) begin
        col_cnt++;
        if (sda_oe || scl_oe) col_bad++;
    end

    // Slave model at address SLV.
    bit active = 0, adr_ph = 0, hit = 0, rd = 0, mack = 0;
    int bcnt = 0, start_cnt = 0, stop_cnt = 0, stretch_n = 0;
    logic [7:0] sh = 0, txsh = 0, tx_next = 8'h3C, wr_log = 0, addr_log = 0;
    logic p_sda = 1'b1, p_scl = 1'b1;
    always @(sda_w or scl_w) begin
        if (scl_w && p_scl && p_sda && !sda_w) begin
            active = 1; adr_ph = 1; bcnt = 0; hit = 0; s_sda_low = 0; start_cnt++;
        end else if (scl_w && p_scl && !p_sda && sda_w) begin
            active = 0; s_sda_low = 0; stop_cnt++;
        end else if (scl_w && !p_scl && active) begin
            if (bcnt < 8) sh = {sh[6:0], sda_w};
            else mack = !sda_w;
            bcnt++;
        end else if (!scl_w && p_scl && active) begin
            if (bcnt == 8) begin
                if (adr_ph) begin
                    addr_log = sh; hit = (sh[7:1] == SLV); rd = sh[0]; s_sda_low = hit;
                end else if (!rd) begin
                    if (hit) wr_log = sh;
                    s_sda_low = hit;
                end else s_sda_low = 0;
            end else if (bcnt == 9) begin
                bcnt = 0;
                if (hit && rd && (adr_ph || mack)) begin
                    txsh = tx_next; tx_next = tx_next + 8'h13;
                    s_sda_low = !txsh[7]; txsh = txsh << 1;
                end else s_sda_low = 0;
                adr_ph = 0;
            end else if (hit && rd && !adr_ph && bcnt >= 1 && bcnt < 8) begin
                s_sda_low = !txsh[7]; txsh = txsh << 1;
            end
        end
        p_sda = sda_w;
        p_scl = scl_w;
    end

    // Slave clock stretch after each falling SCL edge.
    always @(negedge scl_w) if (active && stretch_n > 0) begin
        s_scl_low = 1'b1;
        repeat (stretch_n) @(posedge clk);
        s_scl_low = 1'b0;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    logic r_ack, r_rs;
    logic [7:0] r_rx;
    int r_done_cyc, r_edge, r_start_cyc;

    task automatic do_cmd(input logic [2:0] code, input logic [7:0] data, input logic nack);
        while (busy) @(negedge clk);
        cmd_code = code; cmd_data = data; cmd_nack = nack; cmd_valid = 1'b1;
        r_start_cyc = cyc;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!done) @(negedge clk);
        r_ack = ack_ok; r_rx = rx_data; r_rs = restart_req;
        r_done_cyc = cyc; r_edge = last_edge;
        @(negedge clk);
    endtask

    function automatic logic [7:0] addr_byte(input logic [6:0] a, input bit r);
        return {a, r};
    endfunction

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] exp_tx;
        int d0, d1, c0, s0;
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!sda_oe && !scl_oe, "R1 enables", {sda_oe, scl_oe}, 0);
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);

        // R2/R3/R4/R6 directed write
        do_cmd(3'd1, {1'b0, SLV}, 1'b0);
        chk(addr_log == addr_byte(SLV, 0), "R2 write address", addr_log, addr_byte(SLV, 0));
        chk(r_ack == 1'b1, "R3 ack on address", r_ack, 1);
        chk(scl_oe == 1'b1, "R3 SCL held low", scl_oe, 1);
        do_cmd(3'd3, 8'hA5, 1'b0);
        d0 = r_done_cyc - r_start_cyc;
        chk(wr_log == 8'hA5, "R4 written byte", wr_log, 8'hA5);
        chk(r_ack == 1'b1, "R4 data ack", r_ack, 1);
        s0 = stop_cnt;
        do_cmd(3'd5, 8'h00, 1'b0);
        chk(stop_cnt == s0 + 1, "R6 stop seen", stop_cnt, s0 + 1);
        chk(!sda_oe && !scl_oe && sda_w && scl_w, "R6 bus released", {sda_oe, scl_oe}, 0);

        // R3 wrong address gives NACK
        do_cmd(3'd1, 8'h11, 1'b0);
        chk(r_ack == 1'b0, "R3 nack on absent address", r_ack, 0);
        do_cmd(3'd5, 8'h00, 1'b0);

        // R5 reads with ACK then NACK, R11 repeated start
        exp_tx = tx_next;
        do_cmd(3'd2, {1'b0, SLV}, 1'b0);
        chk(addr_log == addr_byte(SLV, 1), "R2 read address", addr_log, addr_byte(SLV, 1));
        do_cmd(3'd4, 8'h00, 1'b0);
        chk(r_rx == exp_tx, "R5 first read byte", r_rx, exp_tx);
        chk(mack == 1'b1, "R5 master ack driven", mack, 1);
        exp_tx = exp_tx + 8'h13;
        do_cmd(3'd4, 8'h00, 1'b1);
        chk(r_rx == exp_tx, "R5 second read byte", r_rx, exp_tx);
        chk(mack == 1'b0, "R5 master nack", mack, 0);
        exp_tx = exp_tx + 8'h13;
        c0 = start_cnt;
        do_cmd(3'd1, {1'b0, SLV}, 1'b0);
        chk(start_cnt == c0 + 1 && r_ack, "R11 repeated start acked", start_cnt, c0 + 1);
        do_cmd(3'd3, 8'h6C, 1'b0);
        chk(wr_log == 8'h6C, "R11 write after repeated start", wr_log, 8'h6C);

        // R10 command while busy is ignored
        s0 = stop_cnt;
        fork
            do_cmd(3'd3, 8'h5E, 1'b0);
            begin
                repeat (20) @(negedge clk);
                chk(busy == 1'b1, "R10 busy during byte", busy, 1);
                cmd_code = 3'd5; cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        chk(stop_cnt == s0 && wr_log == 8'h5E, "R10 ignored stop", stop_cnt, s0);
        chk(scl_oe == 1'b1, "R10 SCL still held", scl_oe, 1);
        do_cmd(3'd5, 8'h00, 1'b0);

        // R7 stretching
        stretch_n = 14;
        do_cmd(3'd1, {1'b0, SLV}, 1'b0);
        do_cmd(3'd3, 8'hC3, 1'b0);
        d1 = r_done_cyc - r_start_cyc;
        chk(wr_log == 8'hC3 && r_ack, "R7 write under stretch", wr_log, 8'hC3);
        chk(d1 > d0, "R7 stretch lengthens byte", d1, d0);
        do_cmd(3'd2, {1'b0, SLV}, 1'b0);
        do_cmd(3'd4, 8'h00, 1'b1);
        chk(r_rx == exp_tx, "R7 read under stretch", r_rx, exp_tx);
        exp_tx = exp_tx + 8'h13;
        do_cmd(3'd5, 8'h00, 1'b0);
        stretch_n = 0;

        // R8/R9 collision in address phase
        c0 = col_cnt;
        fork
            begin @(negedge sda_w); rival_low = 1'b1; end
            do_cmd(3'd1, {1'b0, SLV}, 1'b0);
            begin
                wait (col_cnt == c0 + 1);
                repeat (40) @(posedge clk);
                rival_low = 1'b0;
                d0 = cyc;
            end
        join
        chk(col_cnt == c0 + 1, "R8 one collision pulse", col_cnt, c0 + 1);
        chk(col_bad == 0, "R8 bus released at collision", col_bad, 0);
        chk(r_rs == 1'b1, "R9 restart request", r_rs, 1);
        chk(r_done_cyc - d0 >= TB_IDLE, "R9 waits after SDA high", r_done_cyc - d0, TB_IDLE);
        chk(r_done_cyc - r_edge >= TB_IDLE, "R9 quiet window", r_done_cyc - r_edge, TB_IDLE);
        do_cmd(3'd1, {1'b0, SLV}, 1'b0);
        chk(r_ack && !r_rs, "R9 restart succeeds", r_ack, 1);
        do_cmd(3'd3, 8'h99, 1'b0);
        chk(wr_log == 8'h99, "R9 data after restart", wr_log, 8'h99);

        // R8 no collision during data bytes
        c0 = col_cnt;
        rival_low = 1'b1;
        do_cmd(3'd3, 8'hFF, 1'b0);
        chk(col_cnt == c0 && !r_rs, "R8 data phase ignores rival", col_cnt, c0);
        rival_low = 1'b0;
        @(negedge clk);
        do_cmd(3'd5, 8'h00, 1'b0);

        // Random transactions (R2 R3 R4 R5 R7)
        for (int i = 0; i < 16; i++) begin
            logic [6:0] a;
            logic [7:0] dat;
            bit hitp, rdp;
            hitp = ($urandom % 4) != 0;
            rdp = $urandom % 2;
            dat = 8'($urandom);
            a = hitp ? SLV : (SLV ^ 7'(1 + $urandom % 127));
            stretch_n = ($urandom % 2) ? int'($urandom % 13) : 0;
            do_cmd(rdp ? 3'd2 : 3'd1, {1'b0, a}, 1'b0);
            chk(r_ack == hitp, "R3 random address ack", r_ack, hitp);
            chk(addr_log == addr_byte(a, rdp), "R2 random address byte", addr_log, addr_byte(a, rdp));
            if (hitp && !rdp) begin
                do_cmd(3'd3, dat, 1'b0);
                chk(wr_log == dat && r_ack, "R4 random write", wr_log, dat);
            end else if (hitp) begin
                do_cmd(3'd4, 8'h00, 1'b1);
                chk(r_rx == exp_tx, "R5 random read", r_rx, exp_tx);
                exp_tx = exp_tx + 8'h13;
            end
            do_cmd(3'd5, 8'h00, 1'b0);
        end
        stretch_n = 0;
        chk(min_hi >= HALF, "R7 minimum SCL high time", min_hi, HALF);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule